// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects interrupt causes for a small 8-bit processor core and turns them into a single request line with a 16-bit service address. Two external pins are conditioned on chip. Each pin can be set to sense a low level or a falling edge. The pins are sampled once per 12-clock machine cycle, so a falling edge is seen when every level is held for at least 12 clocks. Flags from timer 0, timer 1, timer 2 and the serial port enter as plain inputs from their peripherals.

Software reaches two byte-wide registers over a simple special-function-register bus. One is a mask register. The other holds the pin sensing modes and the two pin flags. A fixed order decides which pending source is served first. The core pulses an acknowledge when it accepts the request. At that moment the block latches the service address, clears the flag of an edge-sensed pin, and tells the timer 0 or timer 1 peripheral to drop its overflow flag.

At reset the block also sets the first fetch address. If the code byte at address zero reads FFh, the fetch goes to a loader entry address given as a parameter. Otherwise it goes to address zero.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `irq_req` is 0 and `irq_vec` is 0000h. Both registers read back as 00h.
- R2: The mask register sits at SFR address A8h. Its bits are: bit7 global enable, bit6 reserved, bit5 timer 2, bit4 serial, bit3 timer 1, bit2 pin 1, bit1 timer 0, bit0 pin 0. It reads back what was written, except bit 6, which always reads 0.
- R3: While the global enable bit is 0, `irq_req` stays 0 whatever is pending. One cycle after the bit is written to 1, every pending source is gated only by its own mask bit.
- R4: A pending source whose own mask bit is 0 never raises `irq_req` and is never chosen.
- R5: When several sources are pending, the service order is pin 0 (0003h), timer 0 (000Bh), pin 1 (0013h), timer 1 (001Bh), serial (0023h), timer 2 (002Bh).
- R6: The serial address is requested by `rx_flag` OR `tx_flag`. The timer 2 address is requested by `t2_ovf` OR `t2_ext`.
- R7: The control register sits at SFR address 88h. Its bits are: bit0 pin 0 mode, bit1 pin 0 flag, bit2 pin 1 mode, bit3 pin 1 flag, and bits 7..4 read 0. With mode 1, the flag is set by a high-to-low change between two successive machine-cycle samples. A pin held low does not set the flag again.
- R8: With mode 0, the flag is set on every sample that reads low. An acknowledge does not clear it. Only a software write clears it, and the flag sets again if the pin is still low.
- R9: Acknowledging a pin whose mode is 1 clears that pin's flag in the same edge.
- R10: When `irq_ack` is 1 while `irq_req` is 1, `irq_vec` takes the chosen address on that edge and `irq_req` is 0 for the next cycle. `irq_vec` holds its value until the next accepted acknowledge. An acknowledge while `irq_req` is 0 has no effect.
- R11: On an accepted acknowledge of timer 0 (or timer 1), `t0_clr` (or `t1_clr`) is 1 for exactly the next cycle. No acknowledge of the serial port or of timer 2 pulses either line.
- R12: `boot_addr` is `ISP_ENTRY` when `code_byte0` reads FFh during reset, and 0000h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| pin0_n | input | 1 | External interrupt pin 0 |
| pin1_n | input | 1 | External interrupt pin 1 |
| t0_ovf | input | 1 | Timer 0 overflow flag |
| t1_ovf | input | 1 | Timer 1 overflow flag |
| t2_ovf | input | 1 | Timer 2 overflow flag |
| t2_ext | input | 1 | Timer 2 external flag |
| rx_flag | input | 1 | Serial receive flag |
| tx_flag | input | 1 | Serial transmit flag |
| t0_clr | output | 1 | Request to clear the timer 0 overflow flag |
| t1_clr | output | 1 | Request to clear the timer 1 overflow flag |
| irq_ack | input | 1 | Service acknowledge pulse from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Latched service address |
| code_byte0 | input | 8 | Code byte at address 0, read during reset |
| boot_addr | output | 16 | First fetch address after reset |

## Verification
A register write takes effect on the next edge, and `irq_req` follows one edge after that. The bench therefore waits at least three cycles after changing masks or flag inputs before it samples the request. A pin change passes through two synchroniser stages, waits up to 12 clocks for the next machine-cycle sample, and then enters the flag register. That is at most 15 cycles, so every pin check waits 30 cycles. `irq_vec`, `t0_clr` and `t1_clr` change on the accepting edge itself. The scoreboard monitor compares them at the falling clock edge right after the cycle in which it saw `irq_ack` and `irq_req` both high.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NUM_SRC = 6;
    localparam logic [15:0] VEC_BASE = 16'h0003;
    localparam int VEC_STEP = 8;

    typedef enum logic [2:0] {
        SRC_PIN0 = 3'd0,
        SRC_TM0  = 3'd1,
        SRC_PIN1 = 3'd2,
        SRC_TM1  = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TM2  = 3'd5,
        SRC_NONE = 3'd7
    } src_e;

    typedef struct packed {
        logic ea;
        logic rsvd;
        logic en_tm2;
        logic en_ser;
        logic en_tm1;
        logic en_pin1;
        logic en_tm0;
        logic en_pin0;
    } mask_reg_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic pick_t pick_first(input logic [NUM_SRC-1:0] pend);
        pick_t p;
        p.valid = 1'b0;
        p.src   = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                p.valid = 1'b1;
                p.src   = src_e'(i[2:0]);
            end
        end
        return p;
    endfunction

    function automatic logic [15:0] vec_of(input src_e s);
        logic [15:0] idx;
        idx = {13'd0, s};
        return VEC_BASE + idx * VEC_STEP;
    endfunction

    function automatic mask_reg_t mask_from_byte(input logic [7:0] b);
        mask_reg_t m;
        m      = mask_reg_t'(b);
        m.rsvd = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/vic_tick.sv
module vic_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/vic_pin.sv
module vic_pin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic sw_we,
    input  logic sw_val,
    input  logic hw_clr,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   flag_q;
    logic                   now_s;
    logic                   set_c;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign now_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b1;
        end else if (tick) begin
            last_q <= now_s;
        end
    end

    always_comb begin
        if (!tick) begin
            set_c = 1'b0;
        end else if (edge_mode) begin
            set_c = last_q & ~now_s;
        end else begin
            set_c = ~now_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_c) begin
            flag_q <= 1'b1;
        end else if (hw_clr) begin
            flag_q <= 1'b0;
        end else if (sw_we) begin
            flag_q <= sw_val;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output pick_t              pick,
    output logic [15:0]        vec
);
    always_comb begin
        pick = pick_first(pend);
        vec  = pick.valid ? vec_of(pick.src) : 16'h0000;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter logic [7:0]  MASK_ADDR   = 8'hA8,
    parameter logic [7:0]  CTL_ADDR    = 8'h88,
    parameter logic [15:0] ISP_ENTRY   = 16'hF800,
    parameter int          CLK_PER_MC  = 12,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_we,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    input  logic        pin0_n,
    input  logic        pin1_n,
    input  logic        t0_ovf,
    input  logic        t1_ovf,
    input  logic        t2_ovf,
    input  logic        t2_ext,
    input  logic        rx_flag,
    input  logic        tx_flag,
    output logic        t0_clr,
    output logic        t1_clr,
    input  logic        irq_ack,
    output logic        irq_req,
    output logic [15:0] irq_vec,
    input  logic [7:0]  code_byte0,
    output logic [15:0] boot_addr
);
    localparam int NPIN = 2;

    mask_reg_t           mask_q;
    logic [NPIN-1:0]     mode_q;
    logic [NPIN-1:0]     pin_flag;
    logic [NPIN-1:0]     pin_in;
    logic [NPIN-1:0]     pin_clr;
    logic [NPIN-1:0]     sw_bit;
    logic                tick;
    logic                mask_we;
    logic                ctl_we;
    logic                take;
    logic                req_q;
    logic [15:0]         vec_q;
    logic                t0_clr_q;
    logic                t1_clr_q;
    logic [15:0]         boot_q;
    logic [NUM_SRC-1:0]  pend;
    logic [NUM_SRC-1:0]  mask_vec;
    logic [NUM_SRC-1:0]  armed;
    pick_t               pick;
    logic [15:0]         pick_vec;

    assign mask_we = sfr_we && (sfr_addr == MASK_ADDR);
    assign ctl_we  = sfr_we && (sfr_addr == CTL_ADDR);
    assign take    = irq_ack && req_q;

    assign pin_in = {pin1_n, pin0_n};
    assign sw_bit = {sfr_wdata[3], sfr_wdata[1]};

    vic_tick #(.DIV(CLK_PER_MC)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NPIN; gi++) begin : g_pin
            localparam src_e MY_SRC = (gi == 0) ? SRC_PIN0 : SRC_PIN1;
            assign pin_clr[gi] = take && pick.valid && (pick.src == MY_SRC) && mode_q[gi];

            vic_pin #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .pin_n     (pin_in[gi]),
                .edge_mode (mode_q[gi]),
                .sw_we     (ctl_we),
                .sw_val    (sw_bit[gi]),
                .hw_clr    (pin_clr[gi]),
                .flag      (pin_flag[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= '0;
        end else begin
            if (mask_we) mask_q <= mask_from_byte(sfr_wdata);
            if (ctl_we)  mode_q <= {sfr_wdata[2], sfr_wdata[0]};
        end
    end

    always_comb begin
        pend = '0;
        pend[SRC_PIN0] = pin_flag[0];
        pend[SRC_TM0]  = t0_ovf & ~t0_clr_q;
        pend[SRC_PIN1] = pin_flag[1];
        pend[SRC_TM1]  = t1_ovf & ~t1_clr_q;
        pend[SRC_SER]  = rx_flag | tx_flag;
        pend[SRC_TM2]  = t2_ovf | t2_ext;

        mask_vec = '0;
        mask_vec[SRC_PIN0] = mask_q.en_pin0;
        mask_vec[SRC_TM0]  = mask_q.en_tm0;
        mask_vec[SRC_PIN1] = mask_q.en_pin1;
        mask_vec[SRC_TM1]  = mask_q.en_tm1;
        mask_vec[SRC_SER]  = mask_q.en_ser;
        mask_vec[SRC_TM2]  = mask_q.en_tm2;

        armed = mask_q.ea ? (pend & mask_vec) : '0;
    end

    vic_arbiter arb_i (
        .pend (armed),
        .pick (pick),
        .vec  (pick_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            vec_q    <= 16'h0000;
            t0_clr_q <= 1'b0;
            t1_clr_q <= 1'b0;
        end else begin
            req_q    <= pick.valid && !take;
            t0_clr_q <= take && pick.valid && (pick.src == SRC_TM0);
            t1_clr_q <= take && pick.valid && (pick.src == SRC_TM1);
            if (take && pick.valid) vec_q <= pick_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q <= (code_byte0 == 8'hFF) ? ISP_ENTRY : 16'h0000;
        end
    end

    always_comb begin
        if (sfr_addr == MASK_ADDR) begin
            sfr_rdata = mask_q;
        end else if (sfr_addr == CTL_ADDR) begin
            sfr_rdata = {4'b0000, pin_flag[1], mode_q[1], pin_flag[0], mode_q[0]};
        end else begin
            sfr_rdata = 8'h00;
        end
    end

    assign irq_req   = req_q;
    assign irq_vec   = vec_q;
    assign t0_clr    = t0_clr_q;
    assign t1_clr    = t1_clr_q;
    assign boot_addr = boot_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
    input logic        clk,
    input logic        rst,
    input logic        irq_req,
    input logic        irq_ack,
    input logic [15:0] irq_vec,
    input logic        t0_clr,
    input logic        t1_clr,
    input logic        glob_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_req && irq_vec == 16'h0000));

    assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !irq_req);

    assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !irq_req);

    assert_vec_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(irq_ack && irq_req) |=> $stable(irq_vec));

    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_vec == 16'h0000) || (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h002B));

    assert_clr_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({t0_clr, t1_clr}));

    assert_clr_cause_R11: assert property (@(posedge clk) disable iff (rst)
        (t0_clr || t1_clr) |-> $past(irq_ack && irq_req));
endmodule

bind vec_irq_ctrl vic_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .irq_vec (irq_vec),
    .t0_clr  (t0_clr),
    .t1_clr  (t1_clr),
    .glob_en (mask_q.ea)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
    localparam logic [15:0] ISP = 16'hF800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        pin0_n = 1'b1, pin1_n = 1'b1;
    logic        t0_ovf = 0, t1_ovf = 0, t2_ovf = 0, t2_ext = 0, rx_flag = 0, tx_flag = 0;
    logic        t0_clr, t1_clr;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [7:0]  code_byte0 = 8'hFF;
    logic [15:0] boot_addr;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    logic took = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl #(.ISP_ENTRY(ISP)) dut_i (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .pin0_n(pin0_n),
        .pin1_n(pin1_n), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
        .t2_ext(t2_ext), .rx_flag(rx_flag), .tx_flag(tx_flag), .t0_clr(t0_clr),
        .t1_clr(t1_clr), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
        .code_byte0(code_byte0), .boot_addr(boot_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) took <= irq_ack && irq_req;

    // monitor: compare the latched address one half cycle after an accepted acknowledge
    always @(negedge clk) begin
        if (took) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected ack", irq_vec, 16'hFFFF);
            end else begin
                check("R5 R10 vector", irq_vec, exp_q.pop_front());
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #0.5;
        check(req, {8'h00, sfr_rdata}, {8'h00, exp});
    endtask

    // driver: wait for request, push expected address, pulse acknowledge
    task automatic serve(input logic [15:0] exp);
        int n = 0;
        while (!irq_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R3 R4 request present", {15'd0, irq_req}, 16'd1);
        exp_q.push_back(exp);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R12 boot FF", boot_addr, ISP);
        check("R1 req", {15'd0, irq_req}, 16'd0);
        check("R1 vec", irq_vec, 16'h0000);
        rst = 1'b1; code_byte0 = 8'h12;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R12 boot other", boot_addr, 16'h0000);
        rd_chk("R1 mask", 8'hA8, 8'h00);
        rd_chk("R1 ctl", 8'h88, 8'h00);

        // R2
        wr(8'hA8, 8'hFF);
        rd_chk("R2 bit6 reads 0", 8'hA8, 8'hBF);
        wr(8'hA8, 8'h00);
        rd_chk("R2 cleared", 8'hA8, 8'h00);

        // R3 global gate
        t0_ovf = 1'b1;
        wr(8'hA8, 8'h02);
        cyc(4);
        check("R3 global off", {15'd0, irq_req}, 16'd0);
        wr(8'hA8, 8'h82);
        cyc(3);
        check("R3 global on", {15'd0, irq_req}, 16'd1);
        serve(16'h000B);
        check("R11 t0_clr pulse", {14'd0, t1_clr, t0_clr}, 16'd1);
        check("R10 req drop", {15'd0, irq_req}, 16'd0);
        t0_ovf = 1'b0;
        cyc(1);
        check("R11 t0_clr one cycle", {15'd0, t0_clr}, 16'd0);

        // R4 per-source mask
        t1_ovf = 1'b1;
        cyc(4);
        check("R4 masked timer1", {15'd0, irq_req}, 16'd0);
        wr(8'hA8, 8'h8A);
        serve(16'h001B);
        check("R11 t1_clr pulse", {14'd0, t1_clr, t0_clr}, 16'd2);
        t1_ovf = 1'b0;

        // R6 shared addresses
        wr(8'hA8, 8'hB0);
        rx_flag = 1'b1;
        serve(16'h0023);
        check("R11 no clr on serial", {14'd0, t1_clr, t0_clr}, 16'd0);
        rx_flag = 1'b0;
        tx_flag = 1'b1;
        serve(16'h0023);
        tx_flag = 1'b0;
        t2_ext = 1'b1;
        serve(16'h002B);
        check("R11 no clr on timer2", {14'd0, t1_clr, t0_clr}, 16'd0);
        t2_ext = 1'b0;
        t2_ovf = 1'b1;
        serve(16'h002B);
        t2_ovf = 1'b0;
        cyc(3);
        check("R6 idle after clear", {15'd0, irq_req}, 16'd0);

        // R5 priority order with everything pending
        wr(8'hA8, 8'h00);
        wr(8'h88, 8'h0F);
        t0_ovf = 1; t1_ovf = 1; rx_flag = 1; t2_ovf = 1;
        wr(8'hA8, 8'hBF);
        serve(16'h0003);
        rd_chk("R9 pin0 flag cleared", 8'h88, 8'h0D);
        cyc(2);
        check("R10 vec held", irq_vec, 16'h0003);
        serve(16'h000B);
        t0_ovf = 0;
        serve(16'h0013);
        serve(16'h001B);
        t1_ovf = 0;
        serve(16'h0023);
        rx_flag = 0;
        serve(16'h002B);
        t2_ovf = 0;
        cyc(3);
        check("R5 all served", {15'd0, irq_req}, 16'd0);
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
        cyc(1);
        check("R10 stray ack ignored", irq_vec, 16'h002B);

        // R7 R9 edge-sensed pin 0
        wr(8'hA8, 8'h81);
        wr(8'h88, 8'h01);
        pin0_n = 1'b0;
        cyc(30);
        rd_chk("R7 edge flag set", 8'h88, 8'h03);
        serve(16'h0003);
        rd_chk("R9 edge flag cleared", 8'h88, 8'h01);
        cyc(30);
        rd_chk("R7 held low no reset", 8'h88, 8'h01);
        check("R7 no request", {15'd0, irq_req}, 16'd0);
        pin0_n = 1'b1;
        cyc(30);

        // R8 level-sensed pin 1
        wr(8'hA8, 8'h84);
        wr(8'h88, 8'h00);
        pin1_n = 1'b0;
        cyc(30);
        rd_chk("R8 level flag set", 8'h88, 8'h08);
        serve(16'h0013);
        cyc(2);
        rd_chk("R8 ack keeps flag", 8'h88, 8'h08);
        wr(8'h88, 8'h00);
        cyc(30);
        rd_chk("R8 sets again while low", 8'h88, 8'h08);
        pin1_n = 1'b1;
        cyc(30);
        wr(8'h88, 8'h00);
        cyc(30);
        rd_chk("R8 software clear", 8'h88, 8'h00);
        check("R8 no request", {15'd0, irq_req}, 16'd0);

        cyc(2);
        check("R10 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule